// File: doc/BRIEF.md
# Descriptor DMA Channel Register Block

This block is the software-facing register file of a descriptor-driven DMA controller. A bus master reaches it through a simple memory-mapped slave port that carries single 32-bit word reads and writes. A 4 KB address window is divided into fixed 128-byte slices, one for each channel. Each slice holds a control word, a status word, a command pointer and a set of plain configuration words. Reads return the addressed word in the same cycle.

Software never writes the status word directly. It writes the control word instead, and the upper half of that word is a per-bit mask that selects which status bits take the lower-half value. Only the run, pause, flush and wake flags and the 8-bit device-status field can be set this way. Starting a channel marks it active and sends a one-cycle run request to the channel sequencer. Stopping a channel clears its active and dead flags. The low command-pointer word is locked while the channel runs. When a write to it is accepted, the value is aligned to 16 bytes and a one-cycle descriptor-load request goes out.

The sequencer reports progress with masked updates to a channel's status word. In the cycle it arrives, such an update is applied before any software control write to the same channel.

Top module: `dma_chan_regs`

## Requirements
- R1: The channel is selected by address bits 11:7 and the register index by address bits 6:2. A write reaches only the addressed register of the addressed channel.
- R2: Register indices 2, 4, 5, 6, 7, 8, 9, 11 and 12 are plain 32-bit storage. Each reads back exactly what was last written to it.
- R3: Register indices 10 and 13 through 31 are reserved. They read as zero, and writes to them have no effect.
- R4: A write of word W to index 0 stores W, which reads back from index 0. The status word (index 1, bits 15:0, upper half zero) becomes (W[15:0] & 16'hF0FF & W[31:16]) | (old & ~W[31:16]). Status bits are run 15, pause 14, flush 13, wake 12, dead 11, active 10, branch-taken 8 and device status 7:0.
- R5: If a control write changes the run bit from 1 to 0, the active bit (10) and dead bit (11) are also cleared.
- R6: If the run bit is set after a control write, the active bit is set. Bit c of `run_pulse` is then high for exactly the one cycle after the write edge.
- R7: Bus writes to the status index (1) are ignored.
- R8: A write to the low command pointer (index 3) is ignored while the run or active bit is set, and then no load request is issued.
- R9: An accepted write to index 3 stores the value with bits 3:0 forced to zero. Bit c of `load_req` is then high for exactly the one cycle after the write edge.
- R10: A sequencer update sets status to (seq_value & seq_mask) | (old & ~seq_mask) for channel `seq_ch`. If a control write to the same channel arrives in the same cycle, the sequencer update is applied first and the control write is applied to its result.
- R11: Reset clears every register, `run_pulse` and `load_req`.
- R12: `rd_data` shows the register selected by `req_addr` with no wait state, and it includes a write made at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the 4 KB window |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for req_addr, combinational |
| seq_valid | input | 1 | Sequencer status update strobe |
| seq_ch | input | 5 | Channel targeted by the sequencer update |
| seq_mask | input | 16 | Status bits the update touches |
| seq_value | input | 16 | New values for the masked status bits |
| run_pulse | output | 32 | One-cycle run request per channel |
| load_req | output | 32 | One-cycle descriptor-load request per channel |

## Verification
Any fault in the status merge shows up on the very next read of index 1. It also shows on `run_pulse` one edge after the control write, because the pulse and the new status word are registered at the same edge. A lock that is evaluated wrongly, or a broken alignment, becomes visible on `load_req` and in the index-3 readback within one cycle. A misrouted decode puts one channel's pattern into another channel's slice, and a sweep of every channel and index finds it. Getting the sequencer-versus-software order wrong changes a single status bit that both sides touch in the same cycle.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  // status bit positions
  localparam int ST_RUN    = 15;
  localparam int ST_PAUSE  = 14;
  localparam int ST_FLUSH  = 13;
  localparam int ST_WAKE   = 12;
  localparam int ST_DEAD   = 11;
  localparam int ST_ACTIVE = 10;
  localparam int ST_BT     = 8;

  // bits a control write is allowed to drive to one
  localparam logic [15:0] CTRL_VALUE_MASK = 16'hF0FF;

  // register indices inside a channel slice
  localparam int IX_CTRL  = 0;
  localparam int IX_STAT  = 1;
  localparam int IX_PTRH  = 2;
  localparam int IX_PTRL  = 3;
  localparam int IX_ISEL  = 4;
  localparam int IX_BSEL  = 5;
  localparam int IX_WSEL  = 6;
  localparam int IX_MODE  = 7;
  localparam int IX_D2H   = 8;
  localparam int IX_D2L   = 9;
  localparam int IX_ADRH  = 11;
  localparam int IX_BADH  = 12;
  localparam int STORE_N  = 16;

  function automatic logic [15:0] masked_merge(input logic [15:0] old,
                                               input logic [15:0] mask,
                                               input logic [15:0] value);
    return (value & mask) | (old & ~mask);
  endfunction

  function automatic logic is_plain(input int ix);
    case (ix)
      IX_PTRH, IX_ISEL, IX_BSEL, IX_WSEL, IX_MODE,
      IX_D2H, IX_D2L, IX_ADRH, IX_BADH: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // full effect of a control write on the status word
  function automatic logic [15:0] ctrl_update(input logic [15:0] old,
                                              input logic [31:0] w);
    logic [15:0] n;
    n = masked_merge(old, w[31:16], w[15:0] & CTRL_VALUE_MASK);
    if (old[ST_RUN] && !n[ST_RUN]) begin
      n[ST_ACTIVE] = 1'b0;
      n[ST_DEAD]   = 1'b0;
    end
    if (n[ST_RUN]) n[ST_ACTIVE] = 1'b1;
    return n;
  endfunction

  function automatic logic ptr_locked(input logic [15:0] st);
    return st[ST_RUN] | st[ST_ACTIVE];
  endfunction

  function automatic logic [31:0] align_ptr(input logic [31:0] w);
    return {w[31:4], 4'b0000};
  endfunction

endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode #(
  parameter int ADDR_W   = 12,
  parameter int CH_SHIFT = 7,
  parameter int NUM_CH   = 32,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int FIELD_W = ADDR_W - CH_SHIFT,
  localparam int RIX_W   = CH_SHIFT - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CH_W-1:0]   ch_idx,
  output logic [RIX_W-1:0]  reg_idx,
  output logic              ch_hit
);
  logic [FIELD_W-1:0]  ch_field;
  logic [CH_SHIFT-1:0] offset;

  assign ch_field = addr[ADDR_W-1:CH_SHIFT];
  assign offset   = addr[CH_SHIFT-1:0];
  assign ch_idx   = CH_W'(ch_field);
  assign reg_idx  = RIX_W'(offset >> 2);
  assign ch_hit   = ({1'b0, ch_field} < (FIELD_W+1)'(NUM_CH));
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile #(
  parameter int RIX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RIX_W-1:0] wr_ix,
  input  logic [31:0]      wr_data,
  input  logic             seq_en,
  input  logic [15:0]      seq_mask,
  input  logic [15:0]      seq_value,
  input  logic [RIX_W-1:0] rd_ix,
  output logic [31:0]      rd_data,
  output logic             flag_run,
  output logic             flag_active,
  output logic             flag_dead,
  output logic             run_pulse_o,
  output logic             load_req_o
);
  import dma_regs_pkg::*;

  logic [31:0] ctrl_q;
  logic [15:0] stat_q;
  logic [31:0] ptrl_q;
  logic        run_q;
  logic        load_q;

  // named internal events
  logic        ctrl_wr;
  logic        ptr_try;
  logic        ptr_accept;
  logic [15:0] stat_after_seq;
  logic [15:0] stat_next;
  logic        run_set;

  assign ctrl_wr        = wr_en && (int'(wr_ix) == IX_CTRL);
  assign ptr_try        = wr_en && (int'(wr_ix) == IX_PTRL);
  assign ptr_accept     = ptr_try && !ptr_locked(stat_q);
  assign stat_after_seq = seq_en ? masked_merge(stat_q, seq_mask, seq_value) : stat_q;
  assign stat_next      = ctrl_wr ? ctrl_update(stat_after_seq, wr_data) : stat_after_seq;
  assign run_set        = ctrl_wr && stat_next[ST_RUN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
      ptrl_q <= '0;
      run_q  <= 1'b0;
      load_q <= 1'b0;
    end else begin
      stat_q <= stat_next;
      if (ctrl_wr)    ctrl_q <= wr_data;
      if (ptr_accept) ptrl_q <= align_ptr(wr_data);
      run_q  <= run_set;
      load_q <= ptr_accept;
    end
  end

  logic [31:0] plain_rd [STORE_N];

  for (genvar k = 0; k < STORE_N; k++) begin : g_slot
    if (is_plain(k)) begin : g_reg
      logic [31:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          q <= '0;
        else if (wr_en && int'(wr_ix) == k) q <= wr_data;
      end
      assign plain_rd[k] = q;
    end else begin : g_rsv
      assign plain_rd[k] = '0;
    end
  end

  always_comb begin
    case (int'(rd_ix))
      IX_CTRL: rd_data = ctrl_q;
      IX_STAT: rd_data = {16'h0000, stat_q};
      IX_PTRL: rd_data = ptrl_q;
      default: rd_data = (int'(rd_ix) < STORE_N) ? plain_rd[rd_ix[3:0]] : '0;
    endcase
  end

  assign flag_run    = stat_q[ST_RUN];
  assign flag_active = stat_q[ST_ACTIVE];
  assign flag_dead   = stat_q[ST_DEAD];
  assign run_pulse_o = run_q;
  assign load_req_o  = load_q;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NUM_CH   = 32,
  parameter int ADDR_W   = 12,
  parameter int CH_SHIFT = 7,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RIX_W   = CH_SHIFT - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data,
  input  logic              seq_valid,
  input  logic [CH_W-1:0]   seq_ch,
  input  logic [15:0]       seq_mask,
  input  logic [15:0]       seq_value,
  output logic [NUM_CH-1:0] run_pulse,
  output logic [NUM_CH-1:0] load_req
);
  // named wires used by the bound checker
  logic              bus_wr;
  logic [CH_W-1:0]   dec_ch;
  logic [RIX_W-1:0]  dec_ix;
  logic              dec_hit;
  logic [NUM_CH-1:0] stat_run;
  logic [NUM_CH-1:0] stat_act;
  logic [NUM_CH-1:0] stat_dead;

  logic [31:0] ch_rd [NUM_CH];

  assign bus_wr = req_valid && req_write;

  dma_addr_decode #(
    .ADDR_W  (ADDR_W),
    .CH_SHIFT(CH_SHIFT),
    .NUM_CH  (NUM_CH)
  ) u_dec (
    .addr   (req_addr),
    .ch_idx (dec_ch),
    .reg_idx(dec_ix),
    .ch_hit (dec_hit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_en_c;
    logic seq_en_c;
    assign wr_en_c  = bus_wr && dec_hit && (dec_ch == CH_W'(c));
    assign seq_en_c = seq_valid && (seq_ch == CH_W'(c));

    dma_chan_regfile #(.RIX_W(RIX_W)) u_rf (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en_c),
      .wr_ix      (dec_ix),
      .wr_data    (req_wdata),
      .seq_en     (seq_en_c),
      .seq_mask   (seq_mask),
      .seq_value  (seq_value),
      .rd_ix      (dec_ix),
      .rd_data    (ch_rd[c]),
      .flag_run   (stat_run[c]),
      .flag_active(stat_act[c]),
      .flag_dead  (stat_dead[c]),
      .run_pulse_o(run_pulse[c]),
      .load_req_o (load_req[c])
    );
  end

  assign rd_data = dec_hit ? ch_rd[dec_ch] : '0;
endmodule

// File: rtl/dma_regs_chk.sv
module dma_regs_chk #(
  parameter int NUM_CH   = 32,
  parameter int CH_SHIFT = 7,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RIX_W   = CH_SHIFT - 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [RIX_W-1:0]  dec_ix,
  input logic              seq_valid,
  input logic [CH_W-1:0]   seq_ch,
  input logic [NUM_CH-1:0] run_pulse,
  input logic [NUM_CH-1:0] load_req,
  input logic [NUM_CH-1:0] stat_run,
  input logic [NUM_CH-1:0] stat_act,
  input logic [NUM_CH-1:0] stat_dead
);
  AST_RUN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(run_pulse)); // R6
  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_req)); // R9
  AST_RUN_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (|run_pulse) |-> $past(bus_wr && int'(dec_ix) == 0)); // R6
  AST_LOAD_FROM_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_req) |-> $past(bus_wr && int'(dec_ix) == 3)); // R9

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic seq_on;
    assign seq_on = seq_valid && (seq_ch == CH_W'(c));

    AST_RUN_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      run_pulse[c] |-> (stat_run[c] && stat_act[c])); // R6
    AST_PTR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      load_req[c] |-> !$past(stat_run[c] || stat_act[c])); // R8
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(stat_run[c]) && !$past(seq_on)) |-> (!stat_act[c] && !stat_dead[c])); // R5
  end
endmodule

bind dma_chan_regs dma_regs_chk #(
  .NUM_CH  (NUM_CH),
  .CH_SHIFT(CH_SHIFT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .dec_ix   (dec_ix),
  .seq_valid(seq_valid),
  .seq_ch   (seq_ch),
  .run_pulse(run_pulse),
  .load_req (load_req),
  .stat_run (stat_run),
  .stat_act (stat_act),
  .stat_dead(stat_dead)
);

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;
  localparam int NCH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        seq_valid = 1'b0;
  logic [4:0]  seq_ch = '0;
  logic [15:0] seq_mask = '0;
  logic [15:0] seq_value = '0;
  logic [NCH-1:0] run_pulse;
  logic [NCH-1:0] load_req;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dma_chan_regs i_dma_chan_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .seq_valid(seq_valid), .seq_ch(seq_ch),
    .seq_mask(seq_mask), .seq_value(seq_value),
    .run_pulse(run_pulse), .load_req(load_req)
  );

  function automatic [11:0] adr(input int ch, input int ix);
    return 12'(ch * 128 + ix * 4);
  endfunction

  function automatic [31:0] pat(input int ch, input int ix);
    return 32'(32'h9E3779B9 * 32'(ch * 32 + ix + 1));
  endfunction

  function automatic bit plain_ix(input int ix);
    return (ix == 2) || (ix >= 4 && ix <= 9) || ix == 11 || ix == 12;
  endfunction

  // status after a control write, written bit by bit
  function automatic [15:0] model_ctrl(input [15:0] old, input [31:0] w);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) begin
      bit may_set = (b < 8) || (b >= 12);
      if (w[16+b]) r[b] = may_set ? w[b] : 1'b0;
      else         r[b] = old[b];
    end
    if (r[15]) r[10] = 1'b1;
    else if (old[15]) begin r[10] = 1'b0; r[11] = 1'b0; end
    return r;
  endfunction

  task automatic check(input string tag, input [31:0] act, input [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int ix, input [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = adr(ch, ix); req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr_seq(input int ch, input int ix, input [31:0] d,
                        input [15:0] m, input [15:0] v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = adr(ch, ix); req_wdata = d;
    seq_valid = 1'b1; seq_ch = 5'(ch); seq_mask = m; seq_value = v;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; seq_valid = 1'b0;
  endtask

  task automatic seq(input int ch, input [15:0] m, input [15:0] v);
    @(negedge clk);
    seq_valid = 1'b1; seq_ch = 5'(ch); seq_mask = m; seq_value = v;
    @(posedge clk); #1;
    seq_valid = 1'b0;
  endtask

  task automatic rd(input int ch, input int ix, output [31:0] d);
    req_addr = adr(ch, ix);
    #1;
    d = rd_data;
  endtask

  task automatic next_cycle;
    @(posedge clk); #1;
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] old;
    logic [31:0] w;
    logic [31:0] x;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;

    // R11 reset state
    check("R11 run_pulse", 32'(run_pulse), 32'h0);
    check("R11 load_req", 32'(load_req), 32'h0);
    for (int c = 0; c < NCH; c += 31)
      for (int ix = 0; ix < 16; ix++) begin
        rd(c, ix, d);
        check("R11 reg zero", d, 32'h0);
      end

    // R1 R2 R3 sweep over every channel and index
    for (int c = 0; c < NCH; c++)
      for (int ix = 2; ix < 32; ix++)
        if (ix != 3) wr(c, ix, pat(c, ix));
    for (int c = 0; c < NCH; c++)
      for (int ix = 2; ix < 32; ix++)
        if (ix != 3) begin
          rd(c, ix, d);
          if (plain_ix(ix)) check("R1 R2 R12 plain readback", d, pat(c, ix));
          else              check("R3 reserved reads zero", d, 32'h0);
        end
    for (int c = 0; c < NCH; c += 9) begin
      rd(c, 0, d); check("R1 control untouched", d, 32'h0);
      rd(c, 1, d); check("R1 status untouched", d, 32'h0);
      rd(c, 3, d); check("R1 pointer untouched", d, 32'h0);
    end

    // R7 status not writable from the bus
    wr(5, 1, 32'hFFFF_FFFF);
    rd(5, 1, d); check("R7 status write ignored", d, 32'h0);

    // R10 sequencer update
    seq(3, 16'h0D00, 16'hFFFF);
    rd(3, 1, d); check("R10 seq sets bits", d, 32'h0000_0D00);

    // R4 value limited to writable bits
    wr(3, 0, 32'h0100_0100);
    rd(3, 1, d); check("R4 bt cleared by limited value", d, 32'h0000_0C00);
    rd(3, 0, d); check("R4 control readback", d, 32'h0100_0100);
    wr(3, 0, 32'h00FF_FFA5);
    rd(3, 1, d); check("R4 device status field", d, 32'h0000_0CA5);

    // R6 start
    wr(3, 0, 32'h8000_8000);
    check("R6 run pulse", 32'(run_pulse), 32'h8);
    rd(3, 1, d); check("R6 run and active", d, 32'h0000_8CA5);
    next_cycle();
    check("R6 run pulse one cycle", 32'(run_pulse), 32'h0);

    // R8 locked while running
    wr(3, 3, 32'hABCD_EF01);
    check("R8 no load while run", 32'(load_req), 32'h0);
    rd(3, 3, d); check("R8 pointer unchanged", d, 32'h0);

    // R5 stop clears active and dead
    wr(3, 0, 32'h8000_0000);
    check("R5 no run pulse on stop", 32'(run_pulse), 32'h0);
    rd(3, 1, d); check("R5 stop clears active dead", d, 32'h0000_00A5);

    // R8 locked while active only
    seq(3, 16'h0400, 16'h0400);
    wr(3, 3, 32'hABCD_EF01);
    check("R8 no load while active", 32'(load_req), 32'h0);
    rd(3, 3, d); check("R8 pointer unchanged active", d, 32'h0);
    seq(3, 16'h0400, 16'h0000);

    // R9 accepted pointer write
    wr(3, 3, 32'h1234_567F);
    check("R9 load pulse", 32'(load_req), 32'h8);
    rd(3, 3, d); check("R9 pointer aligned", d, 32'h1234_5670);
    next_cycle();
    check("R9 load pulse one cycle", 32'(load_req), 32'h0);

    // R10 same-cycle ordering
    wr_seq(3, 0, 32'h00FF_005A, 16'h0800, 16'h0800);
    rd(3, 1, d); check("R10 seq then control", d, 32'h0000_085A);
    wr_seq(3, 0, 32'h0001_0000, 16'h0001, 16'h0001);
    rd(3, 1, d); check("R10 control overrides seq", d, 32'h0000_085A);

    // R4 R5 R6 arithmetic sweep on channel 7
    x = 32'h1357_9BDF;
    for (int k = 0; k < 300; k++) begin
      x = x * 32'd1103515245 + 32'd12345;
      if (k % 4 == 0) seq(7, 16'h0D00, x[15:0]);
      w = {x[31:16] | 16'h8000 & {16{x[3]}}, x[15:0]};
      rd(7, 1, old);
      wr(7, 0, w);
      check("R6 run pulse sweep", 32'(run_pulse),
            model_ctrl(old[15:0], w)[15] ? 32'h80 : 32'h0);
      rd(7, 1, d);
      check("R4 R5 status sweep", d, {16'h0, model_ctrl(old[15:0], w)});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule